// File: doc/BRIEF.md
# Parallel ATA Multiword DMA Host Engine

This block is the host end of a multiword DMA burst on a parallel ATA disk bus, covering transfer modes 0, 1 and 2. While enabled and idle, it answers the device's DMA request by raising its acknowledge. It then paces a run of read or write strobes, one data word per strobe. Each strobe holds the asserted and negated widths required by the selected mode. All timing is counted in cycles of a 100 MHz clock, with every nanosecond limit rounded up to whole cycles.

Read words are captured from the bus when the strobe negates. Each one is handed out on a valid/ready stream. Write words are pulled from a valid/ready input stream when their strobe asserts, and are driven on the bus until the data hold time has passed.

After every strobe, the engine waits out the negated window, which also covers the device's request-drop delay. It then samples the request line. If the request has dropped, the engine holds the acknowledge for the hold time and returns to idle. If the request is still high, it issues the next word or, when no word can move, pauses with the acknowledge held.

Top module: `ata_mdma_host`

## Requirements
- R1: After reset, dmack, rd_strb, wr_strb, dd_oe, m_out_valid and s_in_ready are all low.
- R2: A burst starts only when idle with xfer_en and dmarq both high. dmack rises one clock later, and the first strobe rises 5, 3 or 3 clocks after dmack for modes 0, 1 and 2.
- R3: Every strobe stays high for exactly 22, 8 or 7 clocks in modes 0, 1 and 2.
- R4: Between two strobes of one burst, the strobe stays low for exactly 26, 7 or 5 clocks in modes 0, 1 and 2, for both reads and writes. This is the largest of the negated minimum, the cycle-time remainder and the request-drop delay.
- R5: dmarq is sampled when the negated window ends. If it is low, dmack falls 2, 1 or 1 clocks later, so the fall comes 28, 8 or 6 clocks after the last strobe negation in modes 0, 1 and 2.
- R6: In a read burst, dd_in is captured on the clock where rd_strb negates and is offered on m_out_data with m_out_valid. The word is held until m_out_ready, and no further strobe is issued while a word is still pending.
- R7: In a write burst, a word is taken from the input stream (s_in_ready high for one clock) on the clock where wr_strb rises. That word is on dd_out with dd_oe high from that clock until 2, 2 or 1 clocks after wr_strb negates in modes 0, 1 and 2.
- R8: A write burst with no valid input word pauses: the strobe stays low and dmack stays high until a word is offered.
- R9: The mode is taken when a burst starts, and changes to the mode input during a burst have no effect on that burst. Mode code 3 behaves as mode 2.
- R10: A strobe is high only while dmack is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 100 MHz clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Transfer mode 0..2 (3 acts as 2), taken at burst start |
| xfer_en | input | 1 | Allows a new burst to start |
| xfer_write | input | 1 | Direction of the next burst: 1 = write to device |
| dmarq | input | 1 | Device DMA request |
| dmack | output | 1 | Host DMA acknowledge (active high) |
| rd_strb | output | 1 | Read strobe (active high) |
| wr_strb | output | 1 | Write strobe (active high) |
| dd_in | input | 16 | Data from the device bus |
| dd_out | output | 16 | Data to the device bus |
| dd_oe | output | 1 | Bus drive enable for dd_out |
| s_in_data | input | 16 | Write stream word |
| s_in_valid | input | 1 | Write stream word valid |
| s_in_ready | output | 1 | Write stream word taken this clock |
| m_out_data | output | 16 | Read stream word |
| m_out_valid | output | 1 | Read stream word valid |
| m_out_ready | input | 1 | Read stream consumer ready |

## Verification
dmack is due one clock after the request is seen. The first strobe is due 5/3/3 clocks after that, and each strobe edge is due a fixed 22/8/7 or 26/7/5 clocks after the previous one. dmack falls 28/8/6 clocks after the last negation, and dd_oe falls 2/2/1 clocks after each write negation. The bench samples every port on the falling clock edge and stamps each strobe, acknowledge and drive-enable transition with a cycle count. It then compares the differences between stamps against these exact counts rather than looking for a change at some later time. Pauses are checked by waiting a fixed stretch well past the point where a strobe would otherwise be due, and then confirming that none arrived and dmack is still high.

// File: rtl/ata_mdma_host.sv
module ata_mdma_host #(
  parameter int DW     = 16,
  parameter int CLK_NS = 10,
  parameter int CW     = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode,
  input  logic          xfer_en,
  input  logic          xfer_write,
  input  logic          dmarq,
  output logic          dmack,
  output logic          rd_strb,
  output logic          wr_strb,
  input  logic [DW-1:0] dd_in,
  output logic [DW-1:0] dd_out,
  output logic          dd_oe,
  input  logic [DW-1:0] s_in_data,
  input  logic          s_in_valid,
  output logic          s_in_ready,
  output logic [DW-1:0] m_out_data,
  output logic          m_out_valid,
  input  logic          m_out_ready
);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_ACT, S_NEG, S_WAIT, S_HOLD} st_t;

  function automatic logic [CW-1:0] ns2c(input int ns);
    return CW'((ns + CLK_NS - 1) / CLK_NS);
  endfunction

  function automatic logic [CW-1:0] cmax(input logic [CW-1:0] a, input logic [CW-1:0] b);
    return (a > b) ? a : b;
  endfunction

  st_t           st;
  logic [CW-1:0] cnt, oe_cnt, hi_run;
  logic [1:0]    mode_q;
  logic          wr_q, dmack_q, strb_q, oe_q, ovld;
  logic [DW-1:0] dout_q, obuf;

  logic [1:0]    mode_cl, md_sel;
  logic          wr_sel;
  int            a_ns, c_ns, nr_ns, nw_ns, dr_ns, dw_ns, su_ns, ah_ns, ch_ns, dh_ns;
  logic [CW-1:0] t_act, t_neg, t_su, t_hld, t_dh;

  assign mode_cl = (mode == 2'd3) ? 2'd2 : mode;
  assign md_sel  = (st == S_IDLE) ? mode_cl : mode_q;
  assign wr_sel  = (st == S_IDLE) ? xfer_write : wr_q;

  always_comb begin
    case (md_sel)
      2'd0: begin
        a_ns = 215; c_ns = 480; nr_ns = 50; nw_ns = 215; dr_ns = 120; dw_ns = 40;
        su_ns = 50; ah_ns = 20; ch_ns = 15; dh_ns = 20;
      end
      2'd1: begin
        a_ns = 80; c_ns = 150; nr_ns = 50; nw_ns = 50; dr_ns = 40; dw_ns = 40;
        su_ns = 30; ah_ns = 5; ch_ns = 10; dh_ns = 15;
      end
      default: begin
        a_ns = 70; c_ns = 120; nr_ns = 25; nw_ns = 25; dr_ns = 35; dw_ns = 35;
        su_ns = 25; ah_ns = 5; ch_ns = 10; dh_ns = 10;
      end
    endcase
    t_act = ns2c(a_ns);
    t_su  = ns2c(su_ns);
    t_hld = cmax(ns2c(ah_ns), ns2c(ch_ns));
    t_dh  = ns2c(dh_ns);
    t_neg = cmax(cmax(ns2c(wr_sel ? nw_ns : nr_ns), ns2c(c_ns) - t_act),
                 cmax(ns2c(wr_sel ? dw_ns : dr_ns), t_dh));
  end

  logic last, decide, issue_ok, fire;
  assign last     = (cnt == CW'(1));
  assign decide   = (st == S_WAIT) || (((st == S_SETUP) || (st == S_NEG)) && last);
  assign issue_ok = wr_q ? s_in_valid : !ovld;
  assign fire     = decide && dmarq && issue_ok;

  assign dmack       = dmack_q;
  assign rd_strb     = strb_q & ~wr_q;
  assign wr_strb     = strb_q & wr_q;
  assign dd_out      = dout_q;
  assign dd_oe       = oe_q;
  assign s_in_ready  = fire & wr_q;
  assign m_out_data  = obuf;
  assign m_out_valid = ovld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      oe_cnt  <= '0;
      mode_q  <= '0;
      wr_q    <= 1'b0;
      dmack_q <= 1'b0;
      strb_q  <= 1'b0;
      oe_q    <= 1'b0;
      ovld    <= 1'b0;
      dout_q  <= '0;
      obuf    <= '0;
    end else begin
      if (m_out_ready) ovld <= 1'b0;
      if (oe_q && !strb_q) begin
        if (oe_cnt <= CW'(1)) oe_q <= 1'b0;
        else oe_cnt <= oe_cnt - CW'(1);
      end
      case (st)
        S_IDLE: begin
          if (xfer_en && dmarq) begin
            mode_q  <= mode_cl;
            wr_q    <= xfer_write;
            dmack_q <= 1'b1;
            cnt     <= t_su;
            st      <= S_SETUP;
          end
        end
        S_ACT: begin
          if (last) begin
            strb_q <= 1'b0;
            cnt    <= t_neg;
            oe_cnt <= t_dh;
            st     <= S_NEG;
            if (!wr_q) begin
              obuf <= dd_in;
              ovld <= 1'b1;
            end
          end else begin
            cnt <= cnt - CW'(1);
          end
        end
        S_HOLD: begin
          if (last) begin
            dmack_q <= 1'b0;
            st      <= S_IDLE;
          end else begin
            cnt <= cnt - CW'(1);
          end
        end
        default: begin
          if (!decide) begin
            cnt <= cnt - CW'(1);
          end else if (!dmarq) begin
            cnt <= t_hld;
            st  <= S_HOLD;
          end else if (issue_ok) begin
            cnt    <= t_act;
            strb_q <= 1'b1;
            st     <= S_ACT;
            if (wr_q) begin
              dout_q <= s_in_data;
              oe_q   <= 1'b1;
            end
          end else begin
            st <= S_WAIT;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_run <= '0;
    else        hi_run <= strb_q ? hi_run + CW'(1) : '0;
  end

  AST_IDLE_QUIET:    assert property (@(posedge clk) disable iff (!rst_n)
                       (st == S_IDLE) |-> !(strb_q || oe_q || s_in_ready)); // R1
  AST_ACK_COVERS:    assert property (@(posedge clk) disable iff (!rst_n)
                       (rd_strb || wr_strb) |-> dmack); // R10
  AST_ACT_WIDTH:     assert property (@(posedge clk) disable iff (!rst_n)
                       $fell(strb_q) |-> (hi_run == t_act)); // R3
  AST_NO_OVERWRITE:  assert property (@(posedge clk) disable iff (!rst_n)
                       $fell(rd_strb) |-> !$past(ovld)); // R6
  AST_TAKE_ON_RISE:  assert property (@(posedge clk) disable iff (!rst_n)
                       s_in_ready |=> (wr_strb && dd_oe)); // R7
  AST_OE_IN_BURST:   assert property (@(posedge clk) disable iff (!rst_n)
                       dd_oe |-> dmack); // R7
  AST_PAUSE_QUIET:   assert property (@(posedge clk) disable iff (!rst_n)
                       (st == S_WAIT) |-> (dmack && !rd_strb && !wr_strb)); // R8
  AST_MODE_HELD:     assert property (@(posedge clk) disable iff (!rst_n)
                       (dmack && $past(dmack)) |-> $stable(mode_q)); // R9

endmodule

// File: tb/ata_mdma_host_tb.sv
module ata_mdma_host_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int RD_BASE = 16'h4A00;
  localparam int WR_BASE = 16'h9100;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] mode = 2'd0;
  logic xfer_en = 1'b0, xfer_write = 1'b0, dmarq = 1'b0, m_out_ready = 1'b1;
  logic dmack, rd_strb, wr_strb, dd_oe, s_in_ready, s_in_valid, m_out_valid;
  logic [DW-1:0] dd_in, dd_out, s_in_data, m_out_data;

  int n_checks = 0, n_fail = 0;
  int cyc_n = 0, t_ack = 0, t_rise = 0, t_fall = 0, su_meas, end_meas, n_end = 0;
  int hi_min, hi_max, lo_min, lo_max, dh_min, dh_max;
  int n_rise, n_fall, n_rx, rx_bad, wr_bad, target = 0;
  int src_idx = 0, src_avail = 0;
  logic prev_strb = 1'b0, prev_ack = 1'b0, prev_oe = 1'b0, take = 1'b0;

  assign dd_in      = DW'(RD_BASE + n_fall);
  assign s_in_valid = (src_idx < src_avail);
  assign s_in_data  = DW'(WR_BASE + src_idx);

  ata_mdma_host u_dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .xfer_en(xfer_en), .xfer_write(xfer_write),
    .dmarq(dmarq), .dmack(dmack), .rd_strb(rd_strb), .wr_strb(wr_strb),
    .dd_in(dd_in), .dd_out(dd_out), .dd_oe(dd_oe),
    .s_in_data(s_in_data), .s_in_valid(s_in_valid), .s_in_ready(s_in_ready),
    .m_out_data(m_out_data), .m_out_valid(m_out_valid), .m_out_ready(m_out_ready)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    logic strb;
    cyc_n++;
    strb = rd_strb | wr_strb;
    if (dmack && !prev_ack) t_ack = cyc_n;
    if (!dmack && prev_ack) begin end_meas = cyc_n - t_fall; n_end++; end
    if (strb && !prev_strb) begin
      if (n_rise == 0) su_meas = cyc_n - t_ack;
      else begin
        if (cyc_n - t_fall < lo_min) lo_min = cyc_n - t_fall;
        if (cyc_n - t_fall > lo_max) lo_max = cyc_n - t_fall;
      end
      if (wr_strb && (!dd_oe || dd_out != DW'(WR_BASE + n_rise))) wr_bad++;
      t_rise = cyc_n;
      n_rise++;
    end
    if (!strb && prev_strb) begin
      if (cyc_n - t_rise < hi_min) hi_min = cyc_n - t_rise;
      if (cyc_n - t_rise > hi_max) hi_max = cyc_n - t_rise;
      t_fall = cyc_n;
      n_fall++;
      if (n_fall == target) dmarq = 1'b0;
    end
    if (!dd_oe && prev_oe) begin
      if (cyc_n - t_fall < dh_min) dh_min = cyc_n - t_fall;
      if (cyc_n - t_fall > dh_max) dh_max = cyc_n - t_fall;
    end
    if (m_out_valid && m_out_ready) begin
      if (m_out_data != DW'(RD_BASE + n_rx)) rx_bad++;
      n_rx++;
    end
    take = s_in_valid && s_in_ready;
    prev_strb = strb;
    prev_ack = dmack;
    prev_oe = dd_oe;
    if (cyc_n > 150000) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: run did not finish, actual %0d cycles expected < 150000", cyc_n);
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  always @(posedge clk) if (take) begin #1; src_idx++; end

  function automatic int e_act(input int m); return (m == 0) ? 22 : (m == 1) ? 8 : 7; endfunction
  function automatic int e_neg(input int m); return (m == 0) ? 26 : (m == 1) ? 7 : 5; endfunction
  function automatic int e_su (input int m); return (m == 0) ? 5 : 3; endfunction
  function automatic int e_end(input int m); return (m == 0) ? 28 : (m == 1) ? 8 : 6; endfunction
  function automatic int e_dh (input int m); return (m == 2) ? 1 : 2; endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clear_stats();
    n_rise = 0; n_fall = 0; n_rx = 0; rx_bad = 0; wr_bad = 0; src_idx = 0; src_avail = 0;
    hi_min = 9999; hi_max = 0; lo_min = 9999; lo_max = 0; dh_min = 9999; dh_max = 0;
    su_meas = -1; end_meas = -1;
  endtask

  task automatic start_burst(input logic [1:0] m, input logic wr, input int n);
    @(negedge clk);
    clear_stats();
    target = n; mode = m; xfer_write = wr; xfer_en = 1'b1; dmarq = 1'b1;
  endtask

  task automatic wait_end();
    int e0 = n_end;
    for (int i = 0; i < 20000 && n_end == e0; i++) @(negedge clk);
    chk("R5", "burst ended", (n_end != e0) ? 1 : 0, 1);
    xfer_en = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic wait_rise(input int k);
    for (int i = 0; i < 2000 && n_rise < k; i++) @(negedge clk);
  endtask

  task automatic test_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "dmack", int'(dmack), 0);
    chk("R1", "rd_strb", int'(rd_strb), 0);
    chk("R1", "wr_strb", int'(wr_strb), 0);
    chk("R1", "dd_oe", int'(dd_oe), 0);
    chk("R1", "m_out_valid", int'(m_out_valid), 0);
    chk("R1", "s_in_ready", int'(s_in_ready), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic test_gate();
    int seen = 0;
    dmarq = 1'b1; xfer_en = 1'b0;
    repeat (20) begin @(negedge clk); if (dmack) seen++; end
    chk("R2", "no dmack without xfer_en", seen, 0);
    dmarq = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic test_read(input logic [1:0] m_in, input int m, input int n);
    start_burst(m_in, 1'b0, n);
    wait_end();
    chk("R2", "read dmack to first strobe", su_meas, e_su(m));
    chk("R3", "read strobe high min", hi_min, e_act(m));
    chk("R3", "read strobe high max", hi_max, e_act(m));
    chk("R4", "read strobe low min", lo_min, e_neg(m));
    chk("R4", "read strobe low max", lo_max, e_neg(m));
    chk("R5", "read last negation to dmack fall", end_meas, e_end(m));
    chk("R5", "read strobe count", n_rise, n);
    chk("R6", "read words delivered", n_rx, n);
    chk("R6", "read word mismatches", rx_bad, 0);
  endtask

  task automatic test_write(input int m, input int n);
    start_burst(2'(m), 1'b1, n);
    src_avail = n;
    wait_end();
    chk("R2", "write dmack to first strobe", su_meas, e_su(m));
    chk("R3", "write strobe high min", hi_min, e_act(m));
    chk("R3", "write strobe high max", hi_max, e_act(m));
    chk("R4", "write strobe low min", lo_min, e_neg(m));
    chk("R4", "write strobe low max", lo_max, e_neg(m));
    chk("R5", "write last negation to dmack fall", end_meas, e_end(m));
    chk("R7", "write data hold min", dh_min, e_dh(m));
    chk("R7", "write data hold max", dh_max, e_dh(m));
    chk("R7", "write words taken", src_idx, n);
    chk("R7", "write data mismatches", wr_bad, 0);
    chk("R10", "no read strobe in write burst", n_rx, 0);
  endtask

  task automatic test_write_pause();
    start_burst(2'd1, 1'b1, 4);
    src_avail = 2;
    for (int i = 0; i < 2000 && n_fall < 2; i++) @(negedge clk);
    repeat (40) @(negedge clk);
    chk("R8", "strobes during pause", n_rise, 2);
    chk("R8", "dmack held in pause", int'(dmack), 1);
    chk("R8", "strobe low in pause", int'(wr_strb), 0);
    src_avail = 4;
    wait_end();
    chk("R8", "strobes after resume", n_rise, 4);
    chk("R8", "resumed data mismatches", wr_bad, 0);
  endtask

  task automatic test_read_stall();
    m_out_ready = 1'b0;
    start_burst(2'd2, 1'b0, 3);
    for (int i = 0; i < 2000 && n_fall < 1; i++) @(negedge clk);
    repeat (40) @(negedge clk);
    chk("R6", "strobes while word pending", n_rise, 1);
    chk("R6", "word held valid", int'(m_out_valid), 1);
    chk("R6", "held word value", int'(m_out_data), RD_BASE);
    m_out_ready = 1'b1;
    wait_end();
    chk("R6", "stalled burst words", n_rx, 3);
    chk("R6", "stalled burst mismatches", rx_bad, 0);
  endtask

  task automatic test_mode_change();
    start_burst(2'd2, 1'b0, 4);
    wait_rise(1);
    mode = 2'd0;
    wait_end();
    chk("R9", "strobe high after mode change", hi_max, 7);
    chk("R9", "strobe low after mode change", lo_max, 5);
    chk("R9", "words after mode change", n_rx, 4);
  endtask

  initial begin
    test_reset();
    test_gate();
    test_read(2'd0, 0, 3);
    test_read(2'd1, 1, 4);
    test_read(2'd2, 2, 5);
    test_read(2'd3, 2, 3);
    test_write(0, 3);
    test_write(1, 4);
    test_write(2, 5);
    test_write_pause();
    test_read_stall();
    test_mode_change();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule